// File: doc/BRIEF.md
# Multi-thread retire slot selector

In a simultaneous-multithreading core only one hardware thread may retire instructions in a given cycle. This block decides which one. Each thread reports four things: whether it is active, whether its reorder buffer is empty, whether the instruction at the head of that buffer is ready to retire, and that head instruction's sequence number. The block answers in the same cycle with a thread index and a valid bit.

The choice depends on a policy input. The policy can be round-robin over a rotating priority list, which the aggressive setting also uses. It can instead be age-based, in which the thread holding the oldest ready head wins. The policy may change from one cycle to the next. The only state in the block is the priority list. It changes only after a round-robin grant, and that grant moves the winning thread to the back of the list.

Top module: `smt_retire_pick`

## Requirements
- R1: While reset is asserted the priority list returns to ascending thread order, with thread 0 at the front. With no thread active, `pick_valid` is 0 and `pick_idx` is 0.
- R2: When exactly one thread is active, that thread is picked with `pick_valid` = 1, whatever its empty and ready flags say.
- R3: When two or more threads are active, a thread can be picked only if it is eligible. Eligible means it is active, its buffer is non-empty and its head is ready.
- R4: Under round-robin, the pick is the first eligible thread met when walking the priority list from front to back.
- R5: After a round-robin grant the granted thread moves to the back of the priority list. The other threads keep their relative order.
- R6: The policy code decodes as follows: 0 = aggressive, which selects exactly like round-robin; 1 = round-robin; 2 = oldest-ready; 3 = round-robin.
- R7: Under oldest-ready, the pick is the eligible thread with the smallest head sequence number. Sequence numbers are 16-bit unsigned and compared without wraparound. On a tie the lower thread index wins.
- R8: When two or more threads are active and none is eligible, `pick_valid` is 0 and `pick_idx` is 0.
- R9: The priority list changes only on a clock edge where a valid round-robin grant was made among two or more active threads. An oldest-ready pick, a single-thread pick or an invalid cycle leaves the list unchanged.
- R10: The pick is combinational. It reflects the current cycle's inputs and the current priority list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Selection policy code (see R6) |
| thr_active | input | NTHR | Per-thread active flag |
| rob_empty | input | NTHR | Per-thread reorder-buffer-empty flag |
| head_ready | input | NTHR | Per-thread head-ready-to-retire flag |
| head_seq | input | NTHR*SEQW | Head sequence numbers; thread t occupies bits [t*SEQW +: SEQW] |
| pick_idx | output | $clog2(NTHR) | Chosen thread index |
| pick_valid | output | 1 | A thread was chosen |

## Verification
Some properties are checked by assertions on every cycle:
- a picked thread is always eligible;
- an invalid cycle always reports index 0;
- a single active thread always wins;
- an oldest-ready pick never has an older eligible rival;
- two back-to-back round-robin grants with a contested field never go to the same thread.

Other behaviour can only be shown through scenarios in the bench. This covers the exact order the priority list takes after a series of grants. It also covers whether the list stays put across oldest-ready, single-thread and idle cycles, which shows only in which thread a later round-robin cycle picks. The aggressive and spare policy codes, and a reset in mid-run, are covered the same way.

// File: rtl/smt_retire_pick.sv
module smt_retire_pick #(
  parameter int NTHR = 4,
  parameter int SEQW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                policy,
  input  logic [NTHR-1:0]           thr_active,
  input  logic [NTHR-1:0]           rob_empty,
  input  logic [NTHR-1:0]           head_ready,
  input  logic [NTHR*SEQW-1:0]      head_seq,
  output logic [$clog2(NTHR)-1:0]   pick_idx,
  output logic                      pick_valid
);
  localparam int IDXW = $clog2(NTHR);

  logic [IDXW-1:0] prio_q [NTHR];
  logic [NTHR-1:0] elig;
  logic [IDXW:0]   act_cnt;
  logic [IDXW-1:0] solo_idx;
  logic            rr_hit, od_hit;
  logic [IDXW-1:0] rr_idx, rr_pos, od_idx;
  logic [SEQW-1:0] od_seq;
  logic            use_oldest, rr_grant;

  assign elig       = thr_active & ~rob_empty & head_ready;
  assign use_oldest = (policy == 2'd2);

  always_comb begin
    act_cnt  = '0;
    solo_idx = '0;
    for (int t = NTHR - 1; t >= 0; t--) begin
      act_cnt = act_cnt + {{IDXW{1'b0}}, thr_active[t]};
      if (thr_active[t]) solo_idx = IDXW'(t);
    end
  end

  always_comb begin
    rr_hit = 1'b0;
    rr_idx = '0;
    rr_pos = '0;
    for (int p = 0; p < NTHR; p++) begin
      if (!rr_hit && elig[prio_q[p]]) begin
        rr_hit = 1'b1;
        rr_idx = prio_q[p];
        rr_pos = IDXW'(p);
      end
    end
  end

  always_comb begin
    od_hit = 1'b0;
    od_idx = '0;
    od_seq = '1;
    for (int t = 0; t < NTHR; t++) begin
      if (elig[t] && (!od_hit || head_seq[t*SEQW +: SEQW] < od_seq)) begin
        od_hit = 1'b1;
        od_idx = IDXW'(t);
        od_seq = head_seq[t*SEQW +: SEQW];
      end
    end
  end

  always_comb begin
    if (act_cnt == '0) begin
      pick_valid = 1'b0;
      pick_idx   = '0;
    end else if (act_cnt == 1) begin
      pick_valid = 1'b1;
      pick_idx   = solo_idx;
    end else if (use_oldest) begin
      pick_valid = od_hit;
      pick_idx   = od_idx;
    end else begin
      pick_valid = rr_hit;
      pick_idx   = rr_idx;
    end
  end

  assign rr_grant = (act_cnt > 1) && !use_oldest && rr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) prio_q[i] <= IDXW'(i);
    end else if (rr_grant) begin
      for (int i = 0; i < NTHR - 1; i++)
        if (i >= int'(rr_pos)) prio_q[i] <= prio_q[i+1];
      prio_q[NTHR-1] <= rr_idx;
    end
  end
endmodule

// File: rtl/smt_retire_pick_chk.sv
module smt_retire_pick_chk #(
  parameter int NTHR = 4,
  parameter int SEQW = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              policy,
  input logic [NTHR-1:0]         thr_active,
  input logic [NTHR-1:0]         rob_empty,
  input logic [NTHR-1:0]         head_ready,
  input logic [NTHR*SEQW-1:0]    head_seq,
  input logic [$clog2(NTHR)-1:0] pick_idx,
  input logic                    pick_valid
);
  logic [NTHR-1:0] ok;
  logic            older;
  logic            rr_mode;
  int              n_act;

  assign ok      = thr_active & ~rob_empty & head_ready;
  assign rr_mode = (policy != 2'd2);

  always_comb begin
    n_act = $countones(thr_active);
    older = 1'b0;
    for (int t = 0; t < NTHR; t++) begin
      if (ok[t] && (head_seq[t*SEQW +: SEQW] < head_seq[int'(pick_idx)*SEQW +: SEQW] ||
          (head_seq[t*SEQW +: SEQW] == head_seq[int'(pick_idx)*SEQW +: SEQW] && t < int'(pick_idx))))
        older = 1'b1;
    end
  end

  // R8
  invalid_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |-> pick_idx == '0);

  // R3
  picked_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && n_act > 1) |-> ok[pick_idx]);

  // R2
  single_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_act == 1) |-> (pick_valid && thr_active[pick_idx]));

  // R8
  no_elig_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_act > 1) |-> (pick_valid == (ok != '0)));

  // R7
  oldest_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rr_mode && pick_valid && n_act > 1) |-> !older);

  // R5
  rr_moves_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rr_mode && pick_valid && n_act > 1) &&
     rr_mode && n_act > 1 && $countones(ok) > 1) |-> pick_idx != $past(pick_idx));
endmodule

bind smt_retire_pick smt_retire_pick_chk #(.NTHR(NTHR), .SEQW(SEQW)) u_chk (.*);

// File: tb/sim_smt_retire_pick.sv
module sim_smt_retire_pick;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  policy = 2'd1;
  logic [3:0]  thr_active = '0, rob_empty = '0, head_ready = '0;
  logic [63:0] head_seq = '0;
  logic [1:0]  pick_idx;
  logic        pick_valid;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  smt_retire_pick #(.NTHR(4), .SEQW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_active(thr_active),
    .rob_empty(rob_empty), .head_ready(head_ready), .head_seq(head_seq),
    .pick_idx(pick_idx), .pick_valid(pick_valid));

  // {policy, active, empty, ready, seq t3..t0, exp_valid, exp_idx}
  localparam logic [80:0] VEC [10] = '{
    {2'd2, 4'b1111, 4'b0000, 4'b1111, 16'd40, 16'd30, 16'd20, 16'd10, 1'b1, 2'd0},
    {2'd2, 4'b1111, 4'b0000, 4'b1111, 16'd9, 16'd70, 16'd5, 16'd50, 1'b1, 2'd1},
    {2'd2, 4'b1111, 4'b0000, 4'b1011, 16'd4, 16'd1, 16'd8, 16'd9, 1'b1, 2'd3},
    {2'd2, 4'b1111, 4'b1000, 4'b1111, 16'd0, 16'd7, 16'd7, 16'd9, 1'b1, 2'd1},
    {2'd2, 4'b1111, 4'b1100, 4'b1111, 16'd0, 16'd0, 16'hFFFE, 16'hFFFF, 1'b1, 2'd1},
    {2'd2, 4'b1111, 4'b0000, 4'b0000, 16'd1, 16'd2, 16'd3, 16'd4, 1'b0, 2'd0},
    {2'd2, 4'b0100, 4'b0100, 4'b0000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 2'd2},
    {2'd2, 4'b0000, 4'b0000, 4'b1111, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 2'd0},
    {2'd2, 4'b0110, 4'b0000, 4'b1111, 16'd0, 16'd3, 16'd100, 16'd0, 1'b1, 2'd2},
    {2'd2, 4'b0101, 4'b0000, 4'b1111, 16'd0, 16'd9, 16'd0, 16'd5, 1'b1, 2'd0}
  };

  task automatic drive(input logic [1:0] p, input logic [3:0] a, input logic [3:0] e,
                       input logic [3:0] r, input logic [63:0] s);
    @(negedge clk);
    policy = p; thr_active = a; rob_empty = e; head_ready = r; head_seq = s;
    #2;
  endtask

  task automatic expect_pick(input string req, input logic ev, input logic [1:0] ei);
    checks++;
    if (pick_valid !== ev || pick_idx !== ei) begin
      errors++;
      $display("FAIL %s valid=%0d idx=%0d expected valid=%0d idx=%0d",
               req, pick_valid, pick_idx, ev, ei);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    expect_pick("R1 reset idle", 1'b0, 2'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R7 R2 R8 R3: oldest-ready and single/idle vectors
    for (int k = 0; k < 10; k++) begin
      drive(VEC[k][80:79], VEC[k][78:75], VEC[k][74:71], VEC[k][70:67], VEC[k][66:3]);
      expect_pick($sformatf("R7 vector %0d", k), VEC[k][2], VEC[k][1:0]);
    end

    // R4 R5: round-robin walk, list starts 0,1,2,3
    drive(2'd1, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R4 rr first", 1'b1, 2'd0);
    drive(2'd1, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R5 rr after 0", 1'b1, 2'd1);
    drive(2'd1, 4'b1111, 4'b0000, 4'b1001, '0); expect_pick("R5 rr skip", 1'b1, 2'd3);
    drive(2'd1, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R5 rr order", 1'b1, 2'd2);
    // R6 aggressive behaves as round-robin
    drive(2'd0, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R6 aggressive", 1'b1, 2'd0);
    // R8 R9 invalid cycle leaves list
    drive(2'd1, 4'b1111, 4'b0000, 4'b0000, '0); expect_pick("R8 rr none", 1'b0, 2'd0);
    drive(2'd1, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R9 after invalid", 1'b1, 2'd1);
    // R3 empty buffer skipped
    drive(2'd1, 4'b1111, 4'b1000, 4'b1111, '0); expect_pick("R3 empty skipped", 1'b1, 2'd2);
    // R9 oldest-ready does not rotate
    drive(2'd2, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R7 tie low index", 1'b1, 2'd0);
    drive(2'd1, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R9 after oldest", 1'b1, 2'd3);
    // R2 R9 single thread not ready still picked, no rotation
    drive(2'd1, 4'b0001, 4'b0001, 4'b0000, '0); expect_pick("R2 single", 1'b1, 2'd0);
    drive(2'd1, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R9 after single", 1'b1, 2'd0);
    // R6 spare code acts as round-robin
    drive(2'd3, 4'b1111, 4'b0000, 4'b1111, '0); expect_pick("R6 code 3", 1'b1, 2'd1);
    // R10 same-cycle response to changed inputs
    drive(2'd1, 4'b1111, 4'b0000, 4'b0001, '0); expect_pick("R10 comb", 1'b1, 2'd0);

    // R1 mid-run reset restores ascending order
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #2;
    policy = 2'd1; thr_active = 4'b1111; rob_empty = '0; head_ready = 4'b1111;
    #1;
    expect_pick("R1 order after reset", 1'b1, 2'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule